// File: doc/BRIEF.md
# GPIO Bank Interrupt Sense Unit

This block watches a bank of 32 already synchronized GPIO inputs and turns selected pin conditions into sticky per-pin event flags. Each pin is set up on its own as falling edge, rising edge, both edges, level low or level high. One bank can therefore hold a mix of edge and level pins. Software configures the block and acknowledges events through a small word-wide register interface. The block drives one combined interrupt line to a parent controller, which then scans the flag register to find the source.

Edges are found by comparing each input with a copy of itself delayed by one clock. That copy updates on every cycle, whatever the pin's enable or mode, so reconfiguring a pin never creates a false edge. A flag is set only while its pin is enabled and its condition holds. It stays set until software writes 1 to it. For a level pin whose level is still present, the flag sets again on the cycle of the clear.

The register interface is plain: a write strobe with address and data, and read data that follows the address in the same cycle. No transfer takes place in the data path, so there is no handshake.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset the enable, the three mode registers and the flag register all read 0, and `irq_o` is 0.
- R2: The enable register is at byte address 0x00 and the mode registers are at 0x04 (mode bit A), 0x08 (mode bit B) and 0x0C (mode bit C). All four read back what was written. The flag register is at 0x10. Any other address, including a misaligned one such as 0x01, reads 0, and a write to it changes nothing.
- R3: With mode bits A=0, B=0, C=0, a 1-to-0 transition of an enabled pin sets its flag and a 0-to-1 transition does not.
- R4: With A=1, B=0, C=0, a 0-to-1 transition sets the flag and a 1-to-0 transition does not.
- R5: With B=0 and C=1, both transitions set the flag.
- R6: With B=1 the pin is level sensed: A=0 sets the flag while the pin is 0, A=1 while it is 1, and C has no effect.
- R7: A pin whose enable bit is 0 never sets its flag. An edge that happens while the pin is disabled is not remembered when the pin is later enabled.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged, and the other bits are unaffected.
- R9: In level mode, a flag cleared while the level is still present reads 1 again straight after the clear.
- R10: If a pin's condition and a write-1 clear of its flag fall on the same cycle, the flag ends up set.
- R11: `irq_o` is 1 exactly while at least one flag bit is set.
- R12: Changing a pin's mode bits while its input is steady never sets its flag.
- R13: Pins in different modes within one bank flag independently in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS (32) | Synchronized pin values |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (5) | Register byte address |
| bus_wdata | input | NPINS (32) | Write data, one bit per pin |
| bus_rdata | output | NPINS (32) | Read data for `bus_addr`, same cycle |
| irq_o | output | 1 | Combined interrupt, high while any flag is set |

## Verification
The hardest cases to reach from the ports are the races around the flag register. One is a pin condition and a write-1 clear landing on the same clock edge. The other is a mode change on a pin whose input is already steady, where a wrong design would invent an edge. The bench drives the pin change and the clear write at the same falling clock edge, so both are seen at one rising edge. It also holds a pin high while it steps that pin through falling, rising and both-edge modes with the pin enabled, and it toggles a disabled pin before enabling it. After each step it reads the flag register and `irq_o`.

// File: rtl/gis_pkg.sv
`timescale 1ns/1ps
package gis_pkg;

  // Register selector; the first four values index the configuration array.
  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_MODE_A = 3'd1,
    SEL_MODE_B = 3'd2,
    SEL_MODE_C = 3'd3,
    SEL_FLAGS  = 3'd4,
    SEL_NONE   = 3'd7
  } gis_sel_e;

  localparam int unsigned OFF_ENABLE = 'h00;
  localparam int unsigned OFF_MODE_A = 'h04;
  localparam int unsigned OFF_MODE_B = 'h08;
  localparam int unsigned OFF_MODE_C = 'h0C;
  localparam int unsigned OFF_FLAGS  = 'h10;

  // Per-pin trigger mode: lvl selects level sensing, pol picks high/rising,
  // both picks two-edge detection when not level sensed.
  typedef struct packed {
    logic lvl;
    logic pol;
    logic both;
  } gis_mode_t;

  function automatic logic gis_cond(input gis_mode_t m, input logic cur, input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (m.lvl)       return m.pol ? cur : ~cur;
    else if (m.both) return rise | fall;
    else             return m.pol ? rise : fall;
  endfunction

endpackage

// File: rtl/gis_decode.sv
`timescale 1ns/1ps
module gis_decode
  import gis_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output gis_sel_e          sel_o
);

  always_comb begin
    if      (addr_i == ADDR_W'(OFF_ENABLE)) sel_o = SEL_ENABLE;
    else if (addr_i == ADDR_W'(OFF_MODE_A)) sel_o = SEL_MODE_A;
    else if (addr_i == ADDR_W'(OFF_MODE_B)) sel_o = SEL_MODE_B;
    else if (addr_i == ADDR_W'(OFF_MODE_C)) sel_o = SEL_MODE_C;
    else if (addr_i == ADDR_W'(OFF_FLAGS))  sel_o = SEL_FLAGS;
    else                                    sel_o = SEL_NONE;
  end

endmodule

// File: rtl/gis_cfg_regs.sv
`timescale 1ns/1ps
module gis_cfg_regs
  import gis_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  gis_sel_e         sel_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] pol_o,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] both_o
);

  localparam int unsigned NREGS = 4;

  logic [NPINS-1:0] regs_q [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[r] <= '0;
      else if (wr_i && (sel_i == gis_sel_e'(3'(r))))
        regs_q[r] <= wdata_i;
    end
  end

  assign en_o   = regs_q[0];
  assign pol_o  = regs_q[1];
  assign lvl_o  = regs_q[2];
  assign both_o = regs_q[3];

endmodule

// File: rtl/gis_edge_detect.sv
`timescale 1ns/1ps
module gis_edge_detect
  import gis_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] en_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] both_i,
  output logic [NPINS-1:0] hit_o
);

  // Delayed copy tracks the pins unconditionally so mode or enable changes
  // never see a stale history.
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gis_mode_t mode;
    assign mode     = '{lvl: lvl_i[i], pol: pol_i[i], both: both_i[i]};
    assign hit_o[i] = en_i[i] & gis_cond(mode, pin_i[i], prev_q[i]);
  end

endmodule

// File: rtl/gis_flags.sv
`timescale 1ns/1ps
module gis_flags #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] hit_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] flags_o
);

  logic [NPINS-1:0] flags_q;

  // A new hit outranks a clear aimed at the same bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | hit_i;
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/gpio_irq_sense.sv
`timescale 1ns/1ps
module gpio_irq_sense
  import gis_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_o
);

  gis_sel_e         sel;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] pol_q;
  logic [NPINS-1:0] lvl_q;
  logic [NPINS-1:0] both_q;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] clr;
  logic [NPINS-1:0] flags_q;

  gis_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr),
    .sel_o  (sel)
  );

  gis_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr),
    .sel_i   (sel),
    .wdata_i (bus_wdata),
    .en_o    (en_q),
    .pol_o   (pol_q),
    .lvl_o   (lvl_q),
    .both_o  (both_q)
  );

  gis_edge_detect #(.NPINS(NPINS)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .en_i   (en_q),
    .pol_i  (pol_q),
    .lvl_i  (lvl_q),
    .both_i (both_q),
    .hit_o  (hit)
  );

  assign clr = (bus_wr && sel == SEL_FLAGS) ? bus_wdata : '0;

  gis_flags #(.NPINS(NPINS)) u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .clr_i   (clr),
    .flags_o (flags_q)
  );

  always_comb begin
    case (sel)
      SEL_ENABLE: bus_rdata = en_q;
      SEL_MODE_A: bus_rdata = pol_q;
      SEL_MODE_B: bus_rdata = lvl_q;
      SEL_MODE_C: bus_rdata = both_q;
      SEL_FLAGS:  bus_rdata = flags_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_o = |flags_q;

endmodule

// File: rtl/gis_checker.sv
`timescale 1ns/1ps
module gis_checker
  import gis_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPINS-1:0]  pin_i,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_o,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  pol_q,
  input logic [NPINS-1:0]  lvl_q,
  input logic [NPINS-1:0]  both_q,
  input logic [NPINS-1:0]  flags_q
);

  // R1: first cycle out of reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (flags_q == '0 && en_q == '0 && irq_o == 1'b0));

  // R2: configuration only moves on a write
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> ($stable(en_q) && $stable(pol_q) && $stable(lvl_q) && $stable(both_q)));

  // R7: a newly set flag needs its pin enabled on the setting edge
  p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~$past(flags_q) & ~$past(en_q)) == '0);

  // R8: flags drop only after a write to the flag register
  p_w1c_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(bus_wr) && $past(bus_addr) == ADDR_W'(OFF_FLAGS)) |-> (($past(flags_q) & ~flags_q) == '0));

  // R9: an enabled level condition always leaves its flag set
  p_level_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (~flags_q & $past(en_q & lvl_q & ~(pin_i ^ pol_q))) == '0);

  // R11: the interrupt can only rise from an enabled pin
  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(en_q) != '0));

endmodule

bind gpio_irq_sense gis_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_i    (pin_i),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .irq_o    (irq_o),
  .en_q     (en_q),
  .pol_q    (pol_q),
  .lvl_q    (lvl_q),
  .both_q   (both_q),
  .flags_q  (flags_q)
);

// File: tb/tb_gpio_irq_sense.sv
`timescale 1ns/1ps
module tb_gpio_irq_sense;

  localparam int unsigned NPINS  = 32;
  localparam int unsigned ADDR_W = 5;
  localparam realtime     PERIOD = 20.0;

  localparam logic [ADDR_W-1:0] A_EN = 5'h00;
  localparam logic [ADDR_W-1:0] A_MA = 5'h04;
  localparam logic [ADDR_W-1:0] A_MB = 5'h08;
  localparam logic [ADDR_W-1:0] A_MC = 5'h0C;
  localparam logic [ADDR_W-1:0] A_FL = 5'h10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NPINS-1:0]  pins = '0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [NPINS-1:0]  bus_wdata = '0;
  logic [NPINS-1:0]  bus_rdata;
  logic              irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  gpio_irq_sense #(.NPINS(NPINS), .ADDR_W(ADDR_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pins),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input int b, input logic v);
    @(negedge clk);
    pins[b] = v;
    @(negedge clk);
  endtask

  task automatic flags_is(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(A_FL, v);
    chk(tag, v, exp);
  endtask

  task automatic cleanup();
    wr(A_EN, '0); wr(A_MA, '0); wr(A_MB, '0); wr(A_MC, '0);
    @(negedge clk); pins = '0;
    idle(2);
    wr(A_FL, '1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_EN, v); chk("R1 enable", v, 0);
    rd(A_MA, v); chk("R1 modeA", v, 0);
    rd(A_MB, v); chk("R1 modeB", v, 0);
    rd(A_MC, v); chk("R1 modeC", v, 0);
    rd(A_FL, v); chk("R1 flags", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_MA, 32'h1234_5678); wr(A_MB, 32'h0F0F_00FF); wr(A_MC, 32'hCAFE_0001);
    wr(A_EN, 32'hA5A5_5A5A);
    rd(A_EN, v); chk("R2 enable rb", v, 32'hA5A5_5A5A);
    rd(A_MA, v); chk("R2 modeA rb", v, 32'h1234_5678);
    rd(A_MB, v); chk("R2 modeB rb", v, 32'h0F0F_00FF);
    rd(A_MC, v); chk("R2 modeC rb", v, 32'hCAFE_0001);
    wr(5'h14, '1); wr(5'h01, '1);
    rd(5'h14, v); chk("R2 unmapped read", v, 0);
    rd(5'h01, v); chk("R2 misaligned read", v, 0);
    rd(A_EN, v); chk("R2 enable after stray write", v, 32'hA5A5_5A5A);
    rd(A_MA, v); chk("R2 modeA after stray write", v, 32'h1234_5678);
    cleanup();
  endtask

  task automatic t_falling();
    drive(0, 1'b1);
    wr(A_EN, 32'h1);
    drive(0, 1'b0);
    flags_is("R3 fall sets", 32'h1);
    chk("R11 irq on", {31'b0, irq_o}, 1);
    wr(A_FL, 32'h1);
    drive(0, 1'b1);
    flags_is("R3 rise ignored", 32'h0);
    chk("R11 irq off", {31'b0, irq_o}, 0);
    cleanup();
  endtask

  task automatic t_rising();
    wr(A_MA, 32'h2); wr(A_EN, 32'h2);
    drive(1, 1'b1);
    flags_is("R4 rise sets", 32'h2);
    wr(A_FL, 32'h2);
    drive(1, 1'b0);
    flags_is("R4 fall ignored", 32'h0);
    cleanup();
  endtask

  task automatic t_both();
    wr(A_MA, 32'h4); wr(A_MC, 32'h4); wr(A_EN, 32'h4);
    drive(2, 1'b1);
    flags_is("R5 rise sets", 32'h4);
    wr(A_FL, 32'h4);
    flags_is("R8 cleared", 32'h0);
    drive(2, 1'b0);
    flags_is("R5 fall sets", 32'h4);
    cleanup();
  endtask

  task automatic t_level();
    // bit3 level low, bit4 level high with mode C set (must be ignored)
    wr(A_MA, 32'h10); wr(A_MB, 32'h18); wr(A_MC, 32'h10);
    wr(A_EN, 32'h18);
    idle(1);
    flags_is("R6 level low sets", 32'h08);
    wr(A_FL, 32'h08);
    flags_is("R9 level resets after clear", 32'h08);
    drive(3, 1'b1);
    wr(A_FL, 32'h08);
    flags_is("R6 level low gone", 32'h00);
    drive(4, 1'b1);
    flags_is("R6 level high sets", 32'h10);
    drive(4, 1'b0);
    wr(A_FL, 32'h10);
    idle(1);
    flags_is("R6 mode C ignored in level", 32'h00);
    cleanup();
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    // bit5 falling but disabled
    drive(5, 1'b1);
    drive(5, 1'b0);
    flags_is("R7 disabled no flag", 32'h0);
    chk("R7 irq stays low", {31'b0, irq_o}, 0);
    // bit15 rising, edge while disabled, then enabled
    wr(A_MA, 32'h8000);
    drive(15, 1'b1);
    wr(A_EN, 32'h8000);
    idle(2);
    flags_is("R7 old edge forgotten", 32'h0);
    cleanup();
    // bit6 held high through mode changes while enabled
    drive(6, 1'b1);
    idle(1);
    wr(A_EN, 32'h40);
    idle(2);
    flags_is("R12 falling mode steady high", 32'h0);
    wr(A_MA, 32'h40);
    idle(2);
    flags_is("R12 switch to rising", 32'h0);
    wr(A_MC, 32'h40);
    idle(2);
    flags_is("R12 switch to both", 32'h0);
    drive(6, 1'b0);
    flags_is("R12 real edge still seen", 32'h40);
    rd(A_EN, v);
    chk("R12 enable intact", v, 32'h40);
    cleanup();
  endtask

  task automatic t_w1c();
    @(negedge clk); pins[8:7] = 2'b11;
    idle(1);
    wr(A_EN, 32'h180);
    @(negedge clk); pins[8:7] = 2'b00;
    @(negedge clk);
    flags_is("R8 two flags set", 32'h180);
    wr(A_FL, 32'h0);
    flags_is("R8 write zero keeps", 32'h180);
    wr(A_FL, 32'h80);
    flags_is("R8 selective clear", 32'h100);
    chk("R11 irq with one flag", {31'b0, irq_o}, 1);
    wr(A_FL, 32'h100);
    flags_is("R8 last clear", 32'h0);
    chk("R11 irq drops", {31'b0, irq_o}, 0);
    cleanup();
  endtask

  task automatic t_collide();
    drive(9, 1'b1);
    drive(10, 1'b1);
    wr(A_EN, 32'h600);
    drive(10, 1'b0);
    flags_is("R10 setup", 32'h400);
    // same edge: bit9 falls and a clear hits bits 9 and 10
    @(negedge clk);
    pins[9] = 1'b0;
    bus_addr = A_FL; bus_wdata = 32'h600; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    flags_is("R10 set wins, other bit clears", 32'h200);
    cleanup();
  endtask

  task automatic t_mixed();
    // bits 10..14: falling, rising, both, level low, level high
    wr(A_MA, 32'h5800); wr(A_MB, 32'h6000); wr(A_MC, 32'h1000);
    @(negedge clk); pins[14:10] = 5'b01000;
    idle(1);
    wr(A_EN, 32'h7C00);
    idle(1);
    flags_is("R13 quiet after enable", 32'h0);
    @(negedge clk); pins[14:10] = 5'b11111;
    @(negedge clk);
    flags_is("R13 rising group", 32'h5800);
    wr(A_FL, 32'h7C00);
    flags_is("R13 level high survives clear", 32'h4000);
    @(negedge clk); pins[14:10] = 5'b00000;
    @(negedge clk);
    flags_is("R13 falling group", 32'h7400);
    cleanup();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regs();
    t_falling();
    t_rising();
    t_both();
    t_level();
    t_disabled();
    t_w1c();
    t_collide();
    t_mixed();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule